// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer that counts strobes from a slow, low-power oscillator. It is built from two counters in series. The first is a prescaler whose length the user selects as short (`PRE_SHORT_W` bits, 5 by default) or long (`PRE_LONG_W` bits, 7 by default). The second is a postscaler whose ratio is a power of two chosen by a 4-bit select. If software does not clear the watchdog in time, the count reaches the end of its period. At that point the block asks for a device reset, or it asks for a wake-up if the device is asleep.

An optional window mode makes the timer stricter. With window mode on, a clear is honoured only in the last quarter of the period. A clear that arrives earlier is treated as a fault: the block requests a reset and records the cause, and the running count is left alone. The timer runs while either the hardware enable or a software enable register is set, and any device reset clears the software enable. The period selections are captured only while the timer is halted or being restarted, so a period that is already running keeps its length.

Top module: `wdt_window_top`

## Requirements
- R1: During and right after `rst` (synchronous, active high), `rst_req`, `wake_req`, `to_flag` and `viol_flag` are all 0, the count is 0 and the software enable register is 0.
- R2: The timer runs when `hw_en` is 1, or when `hw_en` is 0 and the software enable register is 1. The register takes `sw_en_din` on a cycle with `sw_en_wr` high and is cleared by `rst`. While the timer is halted its count stays at 0, and clear requests have no effect.
- R3: The period is 2^(P+S) oscillator ticks. P is 5 when `pre_long`=0 and 7 when `pre_long`=1. S is the value of `post_sel` (0..15).
- R4: When the tick that completes the period arrives and no restart happens in that cycle, the count wraps to 0. One cycle later the block pulses `wake_req` for one cycle if `sleep`=1, or `rst_req` for one cycle if `sleep`=0. The two requests are never high together.
- R5: With `win_dis`=0, a `clr_req` is accepted when the count is at least 3/4 of the period. An accepted clear sets the count to 0 and produces no request.
- R6: With `win_dis`=0, a `clr_req` while the count is below 3/4 of the period pulses `rst_req` one cycle later and sets `viol_flag`. The count is not restarted, so the next timeout still falls at its original time.
- R7: With `win_dis`=1, a `clr_req` is accepted at any count.
- R8: `psave_req` or `clk_sw` restarts the count at 0.
- R9: `pre_long` and `post_sel` are captured only in cycles where the timer is halted, in reset, or restarted by a clear, `psave_req` or `clk_sw`. Changes at any other time do not alter the running period.
- R10: `to_flag` is set by any timeout or window violation. `viol_flag` is set only by a window violation. Both flags stay set until `rst`.
- R11: If a restart (an accepted clear, `psave_req` or `clk_sw`) falls in the same cycle as the terminal tick, the restart wins and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high device reset |
| osc_tick | input | 1 | One-cycle strobe from the low-power oscillator |
| hw_en | input | 1 | Hardware enable; forces the timer on |
| sw_en_wr | input | 1 | Write strobe for the software enable register |
| sw_en_din | input | 1 | Value written to the software enable register |
| win_dis | input | 1 | 0 selects window mode, 1 allows clears at any count |
| pre_long | input | 1 | Prescaler length: 0 short, 1 long |
| post_sel | input | 4 | Postscaler exponent, ratio 2^post_sel |
| clr_req | input | 1 | Clear request strobe |
| psave_req | input | 1 | Power-save entry strobe |
| clk_sw | input | 1 | Clock-source change strobe |
| sleep | input | 1 | Device is in sleep |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake request |
| to_flag | output | 1 | Sticky watchdog-event status |
| viol_flag | output | 1 | Sticky window-violation status |

## Verification
The delicate overlap is a restart landing on the terminal tick. The bench counts the timer up to exactly one tick before the end of its period. It then issues an accepted clear, and later a power-save strobe, in the cycle where the wrap would happen. The rule is that the restart suppresses the timeout: no request may appear in the following cycle, and the next timeout must come a full period later. A behavioural integer model tracks the count, the captured period and the window limit. Every output is compared with this model on every clock, so the same overlap is also judged cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W  = 4;
  localparam int POST_W = (1 << SEL_W) - 1;

  typedef struct packed {
    logic             pre_long;
    logic [SEL_W-1:0] post_sel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_hold.sv
module wdt_cfg_hold
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  wdt_cfg_t cfg_in,
  output wdt_cfg_t cfg_q
);
  // period selection is frozen except in reset, halt or restart cycles
  always_ff @(posedge clk) begin
    if (rst || load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
  import wdt_pkg::*;
#(
  parameter  int PRE_SHORT_W = 5,
  parameter  int PRE_LONG_W  = 7,
  localparam int POS_W       = PRE_LONG_W + POST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  wdt_cfg_t         cfg,
  output logic [POS_W-1:0] pos,
  output logic             term_hit
);
  localparam logic [PRE_LONG_W-1:0] SHORT_MAX = PRE_LONG_W'((1 << PRE_SHORT_W) - 1);

  logic [PRE_LONG_W-1:0] pre_q, pre_max;
  logic [POST_W-1:0]     post_q, post_max;
  logic                  pre_tc, post_tc;

  always_comb begin
    pre_max  = cfg.pre_long ? '1 : SHORT_MAX;
    post_max = POST_W'((32'd1 << cfg.post_sel) - 32'd1);
    pre_tc   = (pre_q == pre_max);
    post_tc  = (post_q == post_max);
    term_hit = tick && pre_tc && post_tc;
    if (cfg.pre_long) pos = (POS_W'(post_q) << PRE_LONG_W)  | POS_W'(pre_q);
    else              pos = (POS_W'(post_q) << PRE_SHORT_W) | POS_W'(pre_q);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (tick) begin
      if (pre_tc) begin
        pre_q  <= '0;
        post_q <= post_tc ? '0 : post_q + 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter  int PRE_SHORT_W = 5,
  parameter  int PRE_LONG_W  = 7,
  localparam int POS_W       = PRE_LONG_W + POST_W
) (
  input  logic [POS_W-1:0] pos,
  input  wdt_cfg_t         cfg,
  output logic             open
);
  localparam logic [POS_W:0] THREE = (POS_W+1)'(3);

  logic [POS_W:0] lim;
  int             sh;

  // last quarter begins at 3 * 2^(P+S-2)
  always_comb begin
    sh   = (cfg.pre_long ? (PRE_LONG_W - 2) : (PRE_SHORT_W - 2)) + int'(cfg.post_sel);
    lim  = THREE << sh;
    open = ({1'b0, pos} >= lim);
  end
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
  import wdt_pkg::*;
#(
  parameter int PRE_SHORT_W = 5,
  parameter int PRE_LONG_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             hw_en,
  input  logic             sw_en_wr,
  input  logic             sw_en_din,
  input  logic             win_dis,
  input  logic             pre_long,
  input  logic [SEL_W-1:0] post_sel,
  input  logic             clr_req,
  input  logic             psave_req,
  input  logic             clk_sw,
  input  logic             sleep,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_flag,
  output logic             viol_flag
);
  localparam int POS_W = PRE_LONG_W + POST_W;

  logic             sw_en_q, run, win_open, clr_ok, clr_early, restart, term_hit, overflow;
  logic [POS_W-1:0] pos;
  wdt_cfg_t         cfg_in, cfg_q;

  always_comb begin
    cfg_in.pre_long = pre_long;
    cfg_in.post_sel = post_sel;
    run       = hw_en | sw_en_q;
    clr_ok    = run & clr_req & (win_dis | win_open);
    clr_early = run & clr_req & ~win_dis & ~win_open;
    restart   = ~run | clr_ok | psave_req | clk_sw;
    overflow  = term_hit & ~restart;
  end

  always_ff @(posedge clk) begin
    if (rst)           sw_en_q <= 1'b0;
    else if (sw_en_wr) sw_en_q <= sw_en_din;
  end

  wdt_cfg_hold u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load   (restart),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  wdt_tick_counter #(.PRE_SHORT_W(PRE_SHORT_W), .PRE_LONG_W(PRE_LONG_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (restart),
    .tick     (osc_tick),
    .cfg      (cfg_q),
    .pos      (pos),
    .term_hit (term_hit)
  );

  wdt_window #(.PRE_SHORT_W(PRE_SHORT_W), .PRE_LONG_W(PRE_LONG_W)) u_win (
    .pos  (pos),
    .cfg  (cfg_q),
    .open (win_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req   <= 1'b0;
      wake_req  <= 1'b0;
      to_flag   <= 1'b0;
      viol_flag <= 1'b0;
    end else begin
      rst_req   <= (overflow & ~sleep) | clr_early;
      wake_req  <= overflow & sleep;
      to_flag   <= to_flag | overflow | clr_early;
      viol_flag <= viol_flag | clr_early;
    end
  end
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
  parameter int POS_W = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             osc_tick,
  input logic             clr_early,
  input logic             psave_req,
  input logic             clk_sw,
  input logic [POS_W-1:0] pos,
  input logic             rst_req,
  input logic             wake_req,
  input logic             to_flag,
  input logic             viol_flag
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rst_req && !wake_req && !to_flag && !viol_flag));

  a_r2_halted_count_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pos == '0));

  a_r4_requests_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wake_req));

  a_r4_wake_single_cycle: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);

  a_r6_violation_resets: assert property (@(posedge clk) disable iff (rst)
    $rose(viol_flag) |-> rst_req);

  a_r6_count_kept: assert property (@(posedge clk) disable iff (rst)
    (clr_early && !psave_req && !clk_sw && !osc_tick) |=> (pos == $past(pos)));

  a_r10_viol_sticky: assert property (@(posedge clk) disable iff (rst)
    viol_flag |=> viol_flag);

  a_r10_viol_implies_event: assert property (@(posedge clk) disable iff (rst)
    viol_flag |-> to_flag);
endmodule

bind wdt_window_top wdt_window_chk #(.POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .osc_tick  (osc_tick),
  .clr_early (clr_early),
  .psave_req (psave_req),
  .clk_sw    (clk_sw),
  .pos       (pos),
  .rst_req   (rst_req),
  .wake_req  (wake_req),
  .to_flag   (to_flag),
  .viol_flag (viol_flag)
);

// File: tb/wdt_window_top_tb.sv
module wdt_window_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_SHORT    = 5;
  localparam int P_LONG     = 7;

  logic clk = 1'b0;
  logic rst = 1'b1, osc_tick = 1'b1, hw_en = 1'b1, sw_en_wr = 1'b0, sw_en_din = 1'b0;
  logic win_dis = 1'b1, pre_long = 1'b0, clr_req = 1'b0, psave_req = 1'b0, clk_sw = 1'b0, sleep = 1'b0;
  logic [3:0] post_sel = 4'd0;
  logic rst_req, wake_req, to_flag, viol_flag;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 1'b0;

  // behavioural reference state
  int m_cnt = 0, m_sel = 0;
  bit m_sw = 0, m_pl = 0, m_rst = 0, m_wake = 0, m_to = 0, m_viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_window_top dut_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .hw_en(hw_en), .sw_en_wr(sw_en_wr),
    .sw_en_din(sw_en_din), .win_dis(win_dis), .pre_long(pre_long), .post_sel(post_sel),
    .clr_req(clr_req), .psave_req(psave_req), .clk_sw(clk_sw), .sleep(sleep),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag), .viol_flag(viol_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int period;
    bit en, wopen, ok, early, rs, ovf;
    if (rst) begin
      m_cnt = 0; m_sw = 0; m_rst = 0; m_wake = 0; m_to = 0; m_viol = 0;
      m_pl = pre_long; m_sel = int'(post_sel);
    end else begin
      period = 1 << ((m_pl ? P_LONG : P_SHORT) + m_sel);
      en     = hw_en || m_sw;
      wopen  = m_cnt >= period - period / 4;
      ok     = en && clr_req && (win_dis || wopen);
      early  = en && clr_req && !win_dis && !wopen;
      rs     = !en || ok || psave_req || clk_sw;
      ovf    = !rs && osc_tick && (m_cnt == period - 1);
      if (rs) begin
        m_cnt = 0; m_pl = pre_long; m_sel = int'(post_sel);
      end else if (osc_tick) begin
        m_cnt = ovf ? 0 : m_cnt + 1;
      end
      m_rst  = (ovf && !sleep) || early;
      m_wake = ovf && sleep;
      m_to   = m_to || ovf || early;
      m_viol = m_viol || early;
      if (sw_en_wr) m_sw = sw_en_din;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(rst_req == m_rst,    "R4 rst_req vs model",  rst_req,   m_rst);
      chk(wake_req == m_wake,  "R4 wake_req vs model", wake_req,  m_wake);
      chk(to_flag == m_to,     "R10 to_flag vs model", to_flag,   m_to);
      chk(viol_flag == m_viol, "R6 viol_flag vs model", viol_flag, m_viol);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "watchdog expired", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_n(input int n, output int r, output int w);
    r = 0; w = 0;
    repeat (n) begin
      @(negedge clk);
      if (rst_req)  r++;
      if (wake_req) w++;
    end
  endtask

  initial begin
    int r, w, first;
    @(negedge clk);
    cmp_on = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rst_req && !wake_req && !to_flag && !viol_flag, "R1 outputs in reset",
        int'({rst_req, wake_req, to_flag, viol_flag}), 0);
    rst = 1'b0;

    // R3 R4: short prescaler, ratio 1 -> 32 ticks
    first = 0;
    for (int i = 1; i <= 32; i++) begin
      @(negedge clk);
      if (rst_req && first == 0) first = i;
    end
    chk(first == 32, "R3 first timeout cycle", first, 32);
    chk(to_flag && !viol_flag, "R10 flags after timeout", int'({to_flag, viol_flag}), 2);

    sleep = 1'b1;
    wait_n(32, r, w);
    chk(w == 1 && r == 0, "R4 wake instead of reset", w * 10 + r, 10);

    // R5: accepted clear in last quarter
    sleep = 1'b0; win_dis = 1'b0;
    wait_n(24, r, w);
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0;
    chk(!rst_req, "R5 in-window clear no request", rst_req, 0);
    wait_n(31, r, w);
    chk(r == 0, "R5 clear restarted count", r, 0);
    wait_n(1, r, w);
    chk(r == 1, "R5 timeout one period after clear", r, 1);

    // R6: early clear
    wait_n(5, r, w);
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0;
    chk(rst_req && viol_flag, "R6 early clear reset and flag", int'({rst_req, viol_flag}), 3);
    wait_n(25, r, w);
    chk(r == 0, "R6 no extra request", r, 0);
    wait_n(1, r, w);
    chk(r == 1, "R6 count not restarted", r, 1);

    // R7: window disabled, early clear accepted
    win_dis = 1'b1;
    wait_n(3, r, w);
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0;
    chk(!rst_req, "R7 clear accepted anywhere", rst_req, 0);
    wait_n(31, r, w);
    chk(r == 0, "R7 count restarted", r, 0);
    wait_n(1, r, w);
    chk(r == 1, "R7 timeout after clear", r, 1);
    chk(viol_flag, "R10 viol_flag sticky", viol_flag, 1);

    // R11: restart on terminal tick
    wait_n(31, r, w);
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0;
    chk(!rst_req, "R11 clear on terminal tick", rst_req, 0);
    wait_n(31, r, w);
    chk(r == 0, "R11 no timeout after collision", r, 0);
    psave_req = 1'b1; @(negedge clk); psave_req = 1'b0;
    chk(!rst_req, "R11 psave on terminal tick", rst_req, 0);

    // R8: clock switch restarts
    wait_n(10, r, w);
    clk_sw = 1'b1; @(negedge clk); clk_sw = 1'b0;
    wait_n(31, r, w);
    chk(r == 0, "R8 clock switch restart", r, 0);
    wait_n(1, r, w);
    chk(r == 1, "R8 timeout after clock switch", r, 1);

    // R9: selection change mid-count ignored
    post_sel = 4'd3;
    wait_n(31, r, w);
    chk(r == 0, "R9 running period kept", r, 0);
    wait_n(1, r, w);
    chk(r == 1, "R9 old period still used", r, 1);
    psave_req = 1'b1; @(negedge clk); psave_req = 1'b0;
    wait_n(255, r, w);
    chk(r == 0, "R3 ratio 8 no early timeout", r, 0);
    wait_n(1, r, w);
    chk(r == 1, "R3 ratio 8 period 256", r, 1);

    pre_long = 1'b1; post_sel = 4'd0;
    psave_req = 1'b1; @(negedge clk); psave_req = 1'b0;
    wait_n(127, r, w);
    chk(r == 0, "R3 long prescaler no early timeout", r, 0);
    wait_n(1, r, w);
    chk(r == 1, "R3 long prescaler period 128", r, 1);

    // R2: enable paths
    hw_en = 1'b0; win_dis = 1'b0;
    wait_n(300, r, w);
    chk(r + w == 0, "R2 halted no events", r + w, 0);
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0;
    chk(!rst_req, "R2 clear ignored while halted", rst_req, 0);
    sw_en_din = 1'b1; sw_en_wr = 1'b1; @(negedge clk); sw_en_wr = 1'b0;
    wait_n(127, r, w);
    chk(r == 0, "R2 software enable counting", r, 0);
    wait_n(1, r, w);
    chk(r == 1, "R2 software enable timeout", r, 1);

    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk(!to_flag && !viol_flag, "R1 flags cleared by reset", int'({to_flag, viol_flag}), 0);
    wait_n(300, r, w);
    chk(r + w == 0, "R2 reset clears software enable", r + w, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule